// File: doc/BRIEF.md
# Loadable Decimal Digit Counter

This block holds one decimal digit and steps it through 0 to 9. Inside, it is an ordinary 4-bit synchronous binary counter with a parallel load path. A small decoder watches the stored state and, when the digit has to roll over, drives that counter's load or clear path. No modulo compare is used.

A parameter selects one of two roll-over schemes:

- **Reload at nine.** When the count is enabled and the state is nine, the decoder requests a load of zero. The digit becomes zero at the next edge.
- **Clear at ten.** The binary counter is allowed to step into state ten. The decoder sees that state and forces the visible digit to zero in the same cycle by masking it. It also clears the stored state at the next edge.

Both schemes give the same behaviour at the ports.

An external load places any digit from 0 to 9 into the counter. The carry output marks the step that will roll the digit over. Feeding each digit's carry into the next digit's count enable builds a multi-digit decimal counter, for example 0 to 999 with three instances.

Top module: `decade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the digit becomes 0; after that edge `digit` reads 0 and `carryOut` is low while `countEn` is low.
- R2: With `loadEn` low and `countEn` high, a digit below 9 increases by exactly one per clock edge.
- R3: With both `loadEn` and `countEn` low, the digit keeps its value across clock edges.
- R4: With `loadEn` high, the digit takes `loadData` (legal values 0 to 9) at the next edge, whatever `countEn` is. This holds even when the digit is 9 and counting, so the external load wins over the internal roll-over.
- R5: With `loadEn` low, `countEn` high and the digit at 9, the digit reads 0 after the next edge.
- R6: `carryOut` is high exactly when `digit` equals 9 and `countEn` is high.
- R7: `digit` never shows a value above 9, in either roll-over scheme. In the clear-at-ten scheme the stored state ten is never visible.
- R8: Three instances chained through carry to count enable count 0 to 999 in decimal and wrap from 999 to 000.
- R9: The `WRAP_MODE` parameter selects the scheme: value 0 reloads zero at state nine, value 1 clears at state ten. Both give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Advance the digit by one on this edge |
| loadEn | input | 1 | Take `loadData` on this edge |
| loadData | input | 4 | Parallel digit value, 0 to 9 |
| digit | output | 4 | Current decimal digit |
| carryOut | output | 1 | Digit is 9 and counting; drives the next digit's count enable |

## Verification
The interesting collision is an external load and the internal roll-over landing on the same edge. The bench forces this by loading values whose units digit is 9 while counting, and by loading 999 and then loading again on the very next edge. The result is judged against a behavioural decimal reference that lets the load win. It is compared every clock on two three-digit chains, one per roll-over scheme, over more than a thousand counts that include enable gaps.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int DIGIT_W   = 4;
  localparam int TOP_DIGIT = 9;

  typedef enum logic {
    WRAP_RELOAD_AT_NINE = 1'b0,
    WRAP_CLEAR_AT_TEN   = 1'b1
  } wrap_e;

  // strobes from the decoder to the binary counter
  typedef struct packed {
    logic               loadStb;
    logic               incStb;
    logic               clearStb;
    logic [DIGIT_W-1:0] loadValue;
  } ctrl_t;
endpackage

// File: rtl/decade_control.sv
module decade_control
  import decade_pkg::*;
#(
  parameter wrap_e WRAP_MODE = WRAP_RELOAD_AT_NINE
) (
  input  logic               countEn,
  input  logic               loadEn,
  input  logic [DIGIT_W-1:0] loadData,
  input  logic [DIGIT_W-1:0] rawState,
  output ctrl_t              strobes
);
  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(TOP_DIGIT);
  localparam logic [DIGIT_W-1:0] TEN  = DIGIT_W'(TOP_DIGIT + 1);

  generate
    if (WRAP_MODE == WRAP_RELOAD_AT_NINE) begin : g_reload
      logic wrapHit;
      assign wrapHit = (rawState == NINE) && countEn;
      always_comb begin
        strobes.incStb    = countEn;
        strobes.clearStb  = 1'b0;
        // external load has priority over the internal zero reload
        strobes.loadStb   = loadEn | wrapHit;
        strobes.loadValue = loadEn ? loadData : '0;
      end
    end else begin : g_clear
      logic overShoot;
      assign overShoot = (rawState == TEN);
      always_comb begin
        strobes.incStb    = countEn;
        strobes.clearStb  = overShoot;
        strobes.loadStb   = loadEn;
        strobes.loadValue = loadData;
      end
    end
  endgenerate
endmodule

// File: rtl/decade_datapath.sv
module decade_datapath
  import decade_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              strobes,
  output logic [DIGIT_W-1:0] rawState,
  output logic [DIGIT_W-1:0] shownState
);
  logic [DIGIT_W-1:0] stateQ;
  logic [DIGIT_W-1:0] baseVal;
  logic [DIGIT_W-1:0] stateD;

  // a cleared state behaves as zero both on the output and as the count base
  assign baseVal = strobes.clearStb ? '0 : stateQ;

  always_comb begin
    if (strobes.loadStb)     stateD = strobes.loadValue;
    else if (strobes.incStb) stateD = baseVal + DIGIT_W'(1);
    else                     stateD = baseVal;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end

  assign rawState   = stateQ;
  assign shownState = baseVal;
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter wrap_e WRAP_MODE = WRAP_RELOAD_AT_NINE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         countEn,
  input  logic         loadEn,
  input  logic [3:0]   loadData,
  output logic [3:0]   digit,
  output logic         carryOut
);
  ctrl_t              strobes;
  logic [DIGIT_W-1:0] rawState;
  logic [DIGIT_W-1:0] shownState;

  decade_control #(.WRAP_MODE(WRAP_MODE)) u_ctrl (
    .countEn (countEn),
    .loadEn  (loadEn),
    .loadData(loadData),
    .rawState(rawState),
    .strobes (strobes)
  );

  decade_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .rawState  (rawState),
    .shownState(shownState)
  );

  assign digit    = shownState;
  assign carryOut = (shownState == DIGIT_W'(TOP_DIGIT)) && countEn;
endmodule

// File: rtl/decade_counter_checker.sv
module decade_counter_checker (
  input logic       clk,
  input logic       rst,
  input logic       countEn,
  input logic       loadEn,
  input logic [3:0] loadData,
  input logic [3:0] digit,
  input logic       carryOut
);
  assert_digit_range_R7: assert property (@(posedge clk) disable iff (rst)
    digit <= 4'd9);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!countEn && !loadEn) |=> $stable(digit));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    (loadEn && loadData <= 4'd9) |=> (digit == $past(loadData)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (countEn && !loadEn && digit != 4'd9) |=> (digit == $past(digit) + 4'd1));

  assert_rollover_R5: assert property (@(posedge clk) disable iff (rst)
    (carryOut && !loadEn) |=> (digit == 4'd0));

  assert_carry_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    carryOut |-> countEn);
endmodule

bind decade_counter decade_counter_checker u_chk (
  .clk(clk), .rst(rst), .countEn(countEn), .loadEn(loadEn),
  .loadData(loadData), .digit(digit), .carryOut(carryOut)
);

// File: tb/sim_decade_counter.sv
module sim_decade_counter;
  import decade_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic ld = 1'b0;
  logic [3:0] dOnes = '0, dTens = '0, dHund = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int refVal = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // reload-at-nine chain (R9 mode 0)
  logic [3:0] a0, a1, a2;
  logic ac0, ac1, ac2;
  decade_counter #(.WRAP_MODE(WRAP_RELOAD_AT_NINE)) u0 (.clk(clk), .rst(rst),
    .countEn(en), .loadEn(ld), .loadData(dOnes), .digit(a0), .carryOut(ac0));
  decade_counter #(.WRAP_MODE(WRAP_RELOAD_AT_NINE)) u1 (.clk(clk), .rst(rst),
    .countEn(ac0), .loadEn(ld), .loadData(dTens), .digit(a1), .carryOut(ac1));
  decade_counter #(.WRAP_MODE(WRAP_RELOAD_AT_NINE)) u2 (.clk(clk), .rst(rst),
    .countEn(ac1), .loadEn(ld), .loadData(dHund), .digit(a2), .carryOut(ac2));

  // clear-at-ten chain (R9 mode 1)
  logic [3:0] b0, b1, b2;
  logic bc0, bc1, bc2;
  decade_counter #(.WRAP_MODE(WRAP_CLEAR_AT_TEN)) v0 (.clk(clk), .rst(rst),
    .countEn(en), .loadEn(ld), .loadData(dOnes), .digit(b0), .carryOut(bc0));
  decade_counter #(.WRAP_MODE(WRAP_CLEAR_AT_TEN)) v1 (.clk(clk), .rst(rst),
    .countEn(bc0), .loadEn(ld), .loadData(dTens), .digit(b1), .carryOut(bc1));
  decade_counter #(.WRAP_MODE(WRAP_CLEAR_AT_TEN)) v2 (.clk(clk), .rst(rst),
    .countEn(bc1), .loadEn(ld), .loadData(dHund), .digit(b2), .carryOut(bc2));

  // behavioural decimal reference: load wins, otherwise count mod 1000
  always @(posedge clk) begin
    if (rst)     refVal <= 0;
    else if (ld) refVal <= dHund * 100 + dTens * 10 + dOnes;
    else if (en) refVal <= (refVal + 1) % 1000;
  end

  task automatic checkVal(input string tag, input int got, input int exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: compare digits, drive new inputs, compare carries
  task automatic cycle(input string tag, input bit e, input bit l, input int val);
    int ones, tens, hund;
    @(negedge clk);
    checkVal({tag, " R8 reload chain"}, a2 * 100 + a1 * 10 + a0, refVal);
    checkVal({tag, " R8 clear chain"},  b2 * 100 + b1 * 10 + b0, refVal);
    checkVal({tag, " R7 digit range"},  int'(a0 > 9 || b0 > 9 || a1 > 9 || b1 > 9), 0);
    en = e; ld = l;
    dOnes = 4'(val % 10); dTens = 4'((val / 10) % 10); dHund = 4'((val / 100) % 10);
    #1;
    ones = refVal % 10;
    checkVal({tag, " R6 carry reload"}, int'(ac0), int'(e && ones == 9));
    checkVal({tag, " R6 carry clear"},  int'(bc0), int'(e && ones == 9));
    checkVal({tag, " R8 top carry"}, int'(ac2), int'(e && refVal == 999));
    checkVal({tag, " R9 schemes agree"}, int'({ac1, ac2} == {bc1, bc2}), 1);
    tens = 0; hund = 0;
  endtask

  initial begin
    #1000000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checkVal("R1 digit after reset", a0 + b0 + a1 + b1 + a2 + b2, 0);
    checkVal("R1 carry after reset", int'(ac0 | bc0), 0);
    // R2 R5 R8: long run past 999 wraps back to 000
    for (int i = 0; i < 1005; i++) cycle("run", 1'b1, 1'b0, 0);
    // R3: gaps in enable, with holds
    for (int i = 0; i < 60; i++) cycle("gaps", (i % 3) == 0, 1'b0, 0);
    for (int i = 0; i < 5; i++) cycle("R3 hold", 1'b0, 1'b0, 0);
    // R4: load with and without counting
    cycle("R4 load idle", 1'b0, 1'b1, 123);
    for (int i = 0; i < 8; i++) cycle("after load", 1'b1, 1'b0, 0);
    // R4: load while units at 9 and counting (load beats roll-over)
    cycle("R4 preset 909", 1'b0, 1'b1, 909);
    cycle("R4 load over wrap", 1'b1, 1'b1, 99);
    cycle("R4 load over wrap again", 1'b1, 1'b1, 459);
    for (int i = 0; i < 4; i++) cycle("after", 1'b1, 1'b0, 0);
    // R5 R8: 999 boundary, then back-to-back load at 999
    cycle("R5 preset 998", 1'b0, 1'b1, 998);
    for (int i = 0; i < 4; i++) cycle("R5 top wrap", 1'b1, 1'b0, 0);
    cycle("R4 preset 999", 1'b1, 1'b1, 999);
    cycle("R4 reload at 999", 1'b1, 1'b1, 7);
    cycle("R3 hold after load", 1'b0, 1'b0, 0);
    cycle("R1 reset pulse prep", 1'b1, 1'b0, 0);
    @(negedge clk); rst = 1'b1; en = 1'b1;
    @(negedge clk); rst = 1'b0;
    checkVal("R1 digit after second reset", a0 + b0 + a1 + b1 + a2 + b2, 0);
    for (int i = 0; i < 3; i++) cycle("post reset", 1'b1, 1'b0, 0);
    cycle("end", 1'b0, 1'b0, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule